// File: doc/BRIEF.md
# Effective Address Unit with Base Register Auto-Update

This block forms the operand location for a small load/store datapath. Each accepted request carries a 4-bit mode code, two register indices, a signed 16-bit displacement, an absolute location, the current program counter and an immediate value. The unit reads its internal file of eight 32-bit base registers. One clock later it returns one of four things: an effective address, an immediate operand, a register operand, or an illegal-mode flag. All four share a single result bus and each has its own strobe.

Two modes change a base register as a side effect. Post-increment hands out the old base and then steps it up by 4. Pre-decrement steps the base down by 4 and hands out the new value. The memory-indirect mode first publishes the pointer location on a fetch-request strobe and waits. It then returns the word that the memory side hands back as the final address. A separate load port lets the datapath write base registers.

Top module: `addr_mode_unit`

## Requirements
- R1: While reset is low and on the first cycle after it, every output strobe, `busy` and `result` read 0. All base registers read back 0 through mode 1.
- R2: A request is accepted when `req_valid` is high and `busy` is low. Its answer appears on the cycle after the accepting edge. The modes that return an address on `ea_valid` with `result` are: code 2 gives `req_abs`; code 4 gives [Ri]; code 6 gives [Ri]+[Rj].
- R3: The displacement is sign-extended from 16 bits before it is added. Code 5 gives [Ri]+X, code 7 gives [Ri]+[Rj]+X and code 8 gives `req_pc`+X, all modulo 2^32.
- R4: Code 0 raises `imm_valid` with `result` = `req_imm`. Code 1 raises `reg_valid` with `result` = [Ri].
- R5: Code 9 (post-increment) returns the old [Ri] and leaves Ri = old+4. A request on the next cycle sees the new value.
- R6: Code 10 (pre-decrement) writes Ri = old-4 and returns that new value. It wraps modulo 2^32, so 0 gives 0xFFFFFFFC.
- R7: Code 3 (memory indirect) raises `mem_ind_req` for one cycle with `result` = `req_abs`, and `busy` then stays high. On the cycle after `ind_valid` is sampled, `ea_valid` is raised with `result` = `ind_data` and `busy` drops.
- R8: A request presented while `busy` is high is ignored and produces no output strobe.
- R9: Codes 11 to 15 raise `illegal_mode` for one cycle, raise no other strobe and change no register.
- R10: At most one of `ea_valid`, `imm_valid`, `reg_valid`, `mem_ind_req`, `illegal_mode` is high in any cycle.
- R11: `ld_en` writes `ld_data` into register `ld_idx`. When an accepted auto-update targets the same register on the same edge, the auto-update value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 4 | Mode code |
| req_ri | input | 3 | First (base) register index |
| req_rj | input | 3 | Second (index) register index |
| req_ofs | input | 16 | Signed displacement X |
| req_abs | input | 32 | Absolute or pointer location |
| req_pc | input | 32 | Current program counter |
| req_imm | input | 32 | Immediate operand |
| ind_valid | input | 1 | Fetched pointer word valid |
| ind_data | input | 32 | Fetched pointer word |
| ld_en | input | 1 | Base register load strobe |
| ld_idx | input | 3 | Register to load |
| ld_data | input | 32 | Load value |
| busy | output | 1 | Waiting on a pointer fetch |
| ea_valid | output | 1 | Effective address on `result` |
| imm_valid | output | 1 | Immediate operand on `result` |
| reg_valid | output | 1 | Register operand on `result` |
| mem_ind_req | output | 1 | Pointer fetch request, location on `result` |
| illegal_mode | output | 1 | Unused mode code seen |
| result | output | 32 | Shared result bus |

## Verification
The bench uses negative displacements, including the most negative one, relative to the program counter. A design that zero-extended the displacement would land 64 KiB away. It runs post-increments back to back and a pre-decrement through zero. Swapping the old and new values would show up as an address off by four, and a missing write-back would make the next request repeat the same address. It sends a request during a pointer fetch and expects nothing to come out; a unit that accepted it would emit a stray register strobe. It also collides a load with an auto-update on the same register, where the wrong priority would leave the load value in place.

// File: rtl/amu_pkg.sv
package amu_pkg;

  typedef enum logic [3:0] {
    M_IMM   = 4'd0,
    M_REG   = 4'd1,
    M_ABS   = 4'd2,
    M_MIND  = 4'd3,
    M_RIND  = 4'd4,
    M_INDEX = 4'd5,
    M_BIDX  = 4'd6,
    M_BIDXO = 4'd7,
    M_REL   = 4'd8,
    M_AINC  = 4'd9,
    M_ADEC  = 4'd10
  } amode_e;

  typedef enum logic [2:0] {
    K_BAD = 3'd0,
    K_EA  = 3'd1,
    K_IMM = 3'd2,
    K_REG = 3'd3,
    K_IND = 3'd4
  } res_kind_e;

  function automatic logic mode_legal(input logic [3:0] m);
    return m <= M_ADEC;
  endfunction

  function automatic logic mode_updates(input logic [3:0] m);
    return (m == M_AINC) || (m == M_ADEC);
  endfunction

endpackage

// File: rtl/amu_regfile.sv
module amu_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data
);

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0][DW-1:0] regs_d;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wb_hit;
    logic ld_hit;
    assign wb_hit = wb_en && (wb_idx == IW'(g));
    assign ld_hit = ld_en && (ld_idx == IW'(g));
    assign regs_d[g] = wb_hit ? wb_data :
                       ld_hit ? ld_data : regs_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign rd_a = regs_q[rd_a_idx];
  assign rd_b = regs_q[rd_b_idx];

endmodule

// File: rtl/amu_calc.sv
module amu_calc
  import amu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int STEP  = 4
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] ri_val,
  input  logic [AW-1:0] rj_val,
  input  logic [OW-1:0] ofs,
  input  logic [AW-1:0] abs_loc,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] imm,
  output res_kind_e     kind,
  output logic [AW-1:0] value,
  output logic          wb_en,
  output logic [AW-1:0] wb_val
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] sx(input logic [OW-1:0] o);
    return {{(AW-OW){o[OW-1]}}, o};
  endfunction

  function automatic logic [AW-1:0] add3(input logic [AW-1:0] a,
                                         input logic [AW-1:0] b,
                                         input logic [AW-1:0] c);
    return a + b + c;
  endfunction

  logic [AW-1:0] disp;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] inc_val;

  assign disp    = sx(ofs);
  assign dec_val = ri_val - STEP_V;
  assign inc_val = ri_val + STEP_V;

  always_comb begin
    kind   = K_BAD;
    value  = '0;
    wb_en  = 1'b0;
    wb_val = inc_val;
    case (mode)
      M_IMM:   begin kind = K_IMM; value = imm; end
      M_REG:   begin kind = K_REG; value = ri_val; end
      M_ABS:   begin kind = K_EA;  value = abs_loc; end
      M_MIND:  begin kind = K_IND; value = abs_loc; end
      M_RIND:  begin kind = K_EA;  value = ri_val; end
      M_INDEX: begin kind = K_EA;  value = add3(ri_val, disp, '0); end
      M_BIDX:  begin kind = K_EA;  value = add3(ri_val, rj_val, '0); end
      M_BIDXO: begin kind = K_EA;  value = add3(ri_val, rj_val, disp); end
      M_REL:   begin kind = K_EA;  value = add3(pc, disp, '0); end
      M_AINC:  begin
        kind   = K_EA;
        value  = ri_val;
        wb_en  = 1'b1;
        wb_val = inc_val;
      end
      M_ADEC:  begin
        kind   = K_EA;
        value  = dec_val;
        wb_en  = 1'b1;
        wb_val = dec_val;
      end
      default: begin kind = K_BAD; value = '0; end
    endcase
  end

endmodule

// File: rtl/amu_ctrl.sv
module amu_ctrl
  import amu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  res_kind_e     kind,
  input  logic [AW-1:0] value,
  input  logic          ind_valid,
  input  logic [AW-1:0] ind_data,
  output logic          accept,
  output logic          busy,
  output logic          ea_valid,
  output logic          imm_valid,
  output logic          reg_valid,
  output logic          mem_ind_req,
  output logic          illegal_mode,
  output logic [AW-1:0] result
);

  typedef enum logic {S_IDLE = 1'b0, S_WAIT = 1'b1} st_e;
  st_e state_q;

  assign busy   = (state_q == S_WAIT);
  assign accept = req_valid && (state_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      ea_valid     <= 1'b0;
      imm_valid    <= 1'b0;
      reg_valid    <= 1'b0;
      mem_ind_req  <= 1'b0;
      illegal_mode <= 1'b0;
      result       <= '0;
    end else begin
      ea_valid     <= 1'b0;
      imm_valid    <= 1'b0;
      reg_valid    <= 1'b0;
      mem_ind_req  <= 1'b0;
      illegal_mode <= 1'b0;
      if (state_q == S_WAIT) begin
        if (ind_valid) begin
          ea_valid <= 1'b1;
          result   <= ind_data;
          state_q  <= S_IDLE;
        end
      end else if (accept) begin
        result <= value;
        case (kind)
          K_EA:    ea_valid  <= 1'b1;
          K_IMM:   imm_valid <= 1'b1;
          K_REG:   reg_valid <= 1'b1;
          K_IND:   begin
            mem_ind_req <= 1'b1;
            state_q     <= S_WAIT;
          end
          default: begin
            illegal_mode <= 1'b1;
            result       <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/addr_mode_unit.sv
module addr_mode_unit
  import amu_pkg::*;
#(
  parameter int  AW     = 32,
  parameter int  NREG   = 8,
  parameter int  OFS_W  = 16,
  parameter int  STEP   = 4,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_mode,
  input  logic [RIDX_W-1:0] req_ri,
  input  logic [RIDX_W-1:0] req_rj,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [AW-1:0]     req_abs,
  input  logic [AW-1:0]     req_pc,
  input  logic [AW-1:0]     req_imm,
  input  logic              ind_valid,
  input  logic [AW-1:0]     ind_data,
  input  logic              ld_en,
  input  logic [RIDX_W-1:0] ld_idx,
  input  logic [AW-1:0]     ld_data,
  output logic              busy,
  output logic              ea_valid,
  output logic              imm_valid,
  output logic              reg_valid,
  output logic              mem_ind_req,
  output logic              illegal_mode,
  output logic [AW-1:0]     result
);

  logic [AW-1:0] rd_a;
  logic [AW-1:0] rd_b;
  res_kind_e     calc_kind;
  logic [AW-1:0] calc_value;
  logic          calc_wb_en;
  logic [AW-1:0] calc_wb_val;
  logic          accept;
  logic          wb_en;

  assign wb_en = accept && calc_wb_en;

  amu_regfile #(.NREG(NREG), .DW(AW), .IW(RIDX_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (req_ri),
    .rd_b_idx (req_rj),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .wb_en    (wb_en),
    .wb_idx   (req_ri),
    .wb_data  (calc_wb_val),
    .ld_en    (ld_en),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data)
  );

  amu_calc #(.AW(AW), .OW(OFS_W), .STEP(STEP)) u_calc (
    .mode    (req_mode),
    .ri_val  (rd_a),
    .rj_val  (rd_b),
    .ofs     (req_ofs),
    .abs_loc (req_abs),
    .pc      (req_pc),
    .imm     (req_imm),
    .kind    (calc_kind),
    .value   (calc_value),
    .wb_en   (calc_wb_en),
    .wb_val  (calc_wb_val)
  );

  amu_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .kind         (calc_kind),
    .value        (calc_value),
    .ind_valid    (ind_valid),
    .ind_data     (ind_data),
    .accept       (accept),
    .busy         (busy),
    .ea_valid     (ea_valid),
    .imm_valid    (imm_valid),
    .reg_valid    (reg_valid),
    .mem_ind_req  (mem_ind_req),
    .illegal_mode (illegal_mode),
    .result       (result)
  );

endmodule

// File: rtl/amu_checker.sv
module amu_checker
  import amu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RIDX_W = 3,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              busy,
  input logic [3:0]        req_mode,
  input logic [RIDX_W-1:0] req_ri,
  input logic              wb_en,
  input logic [AW-1:0]     rd_a,
  input logic              ea_valid,
  input logic              imm_valid,
  input logic              reg_valid,
  input logic              mem_ind_req,
  input logic              illegal_mode,
  input logic [AW-1:0]     result
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  // R10
  strobes_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ea_valid, imm_valid, reg_valid, mem_ind_req, illegal_mode}));

  // R5
  postinc_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == M_AINC) |=> (ea_valid && result == $past(rd_a)));

  // R6
  predec_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == M_ADEC) |=> (ea_valid && result == $past(rd_a) - STEP_V));

  // R9
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode_legal(req_mode)) |-> !wb_en);

  // R9
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode_legal(req_mode)) |=> (illegal_mode && !ea_valid));

  // R7
  indirect_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ind_req |-> busy);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R5
  wb_only_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (accept && mode_updates(req_mode)));

endmodule

bind addr_mode_unit amu_checker #(.AW(AW), .RIDX_W(RIDX_W), .STEP(STEP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (accept),
  .busy         (busy),
  .req_mode     (req_mode),
  .req_ri       (req_ri),
  .wb_en        (wb_en),
  .rd_a         (rd_a),
  .ea_valid     (ea_valid),
  .imm_valid    (imm_valid),
  .reg_valid    (reg_valid),
  .mem_ind_req  (mem_ind_req),
  .illegal_mode (illegal_mode),
  .result       (result)
);

// File: tb/addr_mode_unit_test.sv
module addr_mode_unit_test;

  localparam int KEA = 0, KIMM = 1, KREG = 2, KBAD = 3, KIND = 4;
  localparam logic [31:0] PC_V  = 32'h0000_4000;
  localparam logic [31:0] ABS_V = 32'h0000_0100;
  localparam logic [31:0] IMM_V = 32'hCAFE_0001;

  // {mode[4], ri[3], rj[3], ofs[16], kind[3], expected[32]} = 61 bits
  localparam int NV = 13;
  localparam logic [60:0] VEC [NV] = '{
    {4'd0,  3'd0, 3'd0, 16'h0000, 3'd1, 32'hCAFE_0001},
    {4'd1,  3'd3, 3'd0, 16'h0000, 3'd2, 32'h0000_4000},
    {4'd2,  3'd0, 3'd0, 16'h0000, 3'd0, 32'h0000_0100},
    {4'd4,  3'd5, 3'd0, 16'h0000, 3'd0, 32'h0000_6000},
    {4'd5,  3'd2, 3'd0, 16'h0010, 3'd0, 32'h0000_3010},
    {4'd5,  3'd2, 3'd0, 16'hFFF0, 3'd0, 32'h0000_2FF0},
    {4'd6,  3'd1, 3'd6, 16'h0000, 3'd0, 32'h0000_9000},
    {4'd7,  3'd0, 3'd7, 16'hFFFC, 3'd0, 32'h0000_8FFC},
    {4'd8,  3'd0, 3'd0, 16'h0020, 3'd0, 32'h0000_4020},
    {4'd8,  3'd0, 3'd0, 16'h8000, 3'd0, 32'hFFFF_C000},
    {4'd11, 3'd0, 3'd0, 16'h0000, 3'd3, 32'h0000_0000},
    {4'd15, 3'd0, 3'd0, 16'h0000, 3'd3, 32'h0000_0000},
    {4'd1,  3'd0, 3'd0, 16'h0000, 3'd2, 32'h0000_1000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_mode = '0;
  logic [2:0]  req_ri = '0;
  logic [2:0]  req_rj = '0;
  logic [15:0] req_ofs = '0;
  logic [31:0] req_abs = ABS_V;
  logic [31:0] req_pc = PC_V;
  logic [31:0] req_imm = IMM_V;
  logic        ind_valid = 1'b0;
  logic [31:0] ind_data = '0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic        busy, ea_valid, imm_valid, reg_valid, mem_ind_req, illegal_mode;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  addr_mode_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_ri(req_ri), .req_rj(req_rj), .req_ofs(req_ofs), .req_abs(req_abs),
    .req_pc(req_pc), .req_imm(req_imm), .ind_valid(ind_valid), .ind_data(ind_data),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .busy(busy),
    .ea_valid(ea_valid), .imm_valid(imm_valid), .reg_valid(reg_valid),
    .mem_ind_req(mem_ind_req), .illegal_mode(illegal_mode), .result(result)
  );

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // strobe vector {ea, imm, reg, ind, bad}
  task automatic expect_out(input string tag, input int kind, input logic [31:0] v);
    logic [4:0] exp_s;
    case (kind)
      KEA:     exp_s = 5'b10000;
      KIMM:    exp_s = 5'b01000;
      KREG:    exp_s = 5'b00100;
      KIND:    exp_s = 5'b00010;
      KBAD:    exp_s = 5'b00001;
      default: exp_s = 5'b00000;
    endcase
    cmp({tag, " strobes"}, {27'd0, ea_valid, imm_valid, reg_valid, mem_ind_req, illegal_mode},
        {27'd0, exp_s});
    if (kind != KBAD && exp_s != 5'b0) cmp({tag, " result"}, result, v);
  endtask

  task automatic issue(input logic [3:0] m, input logic [2:0] ri, input logic [2:0] rj,
                       input logic [15:0] ofs);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_ri = ri; req_rj = rj; req_ofs = ofs;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1:       return "R4";
      4'd2, 4'd4, 4'd6: return "R2";
      4'd5, 4'd7, 4'd8: return "R3";
      default:          return "R9";
    endcase
  endfunction

  initial begin : watchdog
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 strobes in reset", {27'd0, ea_valid, imm_valid, reg_valid, mem_ind_req, illegal_mode}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 busy after reset", {31'd0, busy}, 32'd0);
    cmp("R1 result after reset", result, 32'd0);
    issue(4'd1, 3'd5, 3'd0, 16'h0);
    expect_out("R1 register cleared", KREG, 32'd0);

    // R11: preload bases, R[k] = 0x1000*(k+1)
    for (int k = 0; k < 8; k++) load(3'(k), 32'h1000 * (k + 1));
    issue(4'd1, 3'd7, 3'd0, 16'h0);
    expect_out("R11 load port", KREG, 32'h8000);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [60:0] e;
      e = VEC[v];
      issue(e[60:57], e[56:54], e[53:51], e[50:35]);
      expect_out($sformatf("%s vec%0d", tag_of(e[60:57]), v), int'(e[34:32]), e[31:0]);
    end

    // R10 idle cycle: nothing strobes
    @(negedge clk);
    expect_out("R10 idle", -1, 32'd0);

    // R5: back-to-back post-increment on R4 (0x5000)
    @(negedge clk);
    req_valid = 1'b1; req_mode = 4'd9; req_ri = 3'd4;
    @(negedge clk);
    expect_out("R5 first postinc", KEA, 32'h5000);
    @(negedge clk);
    req_valid = 1'b0;
    expect_out("R5 second postinc", KEA, 32'h5004);
    issue(4'd1, 3'd4, 3'd0, 16'h0);
    expect_out("R5 base after two steps", KREG, 32'h5008);

    // R6: pre-decrement on R6 (0x7000)
    issue(4'd10, 3'd6, 3'd0, 16'h0);
    expect_out("R6 predec", KEA, 32'h6FFC);
    issue(4'd1, 3'd6, 3'd0, 16'h0);
    expect_out("R6 base after predec", KREG, 32'h6FFC);
    load(3'd1, 32'd0);
    issue(4'd10, 3'd1, 3'd0, 16'h0);
    expect_out("R6 predec wrap", KEA, 32'hFFFF_FFFC);

    // R9: illegal code on R3 leaves it alone
    issue(4'd12, 3'd3, 3'd0, 16'h0);
    expect_out("R9 illegal", KBAD, 32'd0);
    issue(4'd1, 3'd3, 3'd0, 16'h0);
    expect_out("R9 register unchanged", KREG, 32'h4000);

    // R11: collision, auto-update wins over load (R2 = 0x3000)
    @(negedge clk);
    req_valid = 1'b1; req_mode = 4'd9; req_ri = 3'd2;
    ld_en = 1'b1; ld_idx = 3'd2; ld_data = 32'hAAAA_0000;
    @(negedge clk);
    req_valid = 1'b0; ld_en = 1'b0;
    expect_out("R11 collision ea", KEA, 32'h3000);
    issue(4'd1, 3'd2, 3'd0, 16'h0);
    expect_out("R11 collision keeps update", KREG, 32'h3004);

    // R7 / R8: memory indirect with a request during the wait
    req_abs = 32'h0000_0200;
    issue(4'd3, 3'd0, 3'd0, 16'h0);
    expect_out("R7 fetch request", KIND, 32'h0000_0200);
    cmp("R7 busy during fetch", {31'd0, busy}, 32'd1);
    req_valid = 1'b1; req_mode = 4'd1; req_ri = 3'd7;
    @(negedge clk);
    req_valid = 1'b0;
    expect_out("R8 request ignored while busy", -1, 32'd0);
    cmp("R7 still busy", {31'd0, busy}, 32'd1);
    ind_valid = 1'b1; ind_data = 32'h1234_5678;
    @(negedge clk);
    ind_valid = 1'b0;
    expect_out("R7 indirect ea", KEA, 32'h1234_5678);
    cmp("R7 busy released", {31'd0, busy}, 32'd0);
    req_abs = ABS_V;

    // R1: reset clears registers again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue(4'd1, 3'd7, 3'd0, 16'h0);
    expect_out("R1 register cleared by reset", KREG, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule